// File: doc/BRIEF.md
# Compact 8-bit Execute Unit

This block is the execute stage of a small 8-bit load/store processor. Each transfer carries a decoded operation, two register operands, a sign-extended immediate and the address of the instruction. The block returns an 8-bit result, a branch-taken flag and a branch target. It covers five register-register operations, the address sum used by loads, stores and load-address, a branch taken when a register is zero, and branch-and-link. Everything is computed combinationally and then captured in one output register stage.

Both sides use a valid/ready handshake. A transfer takes place on a rising edge where valid and ready are both high. The input side is ready whenever the output register is empty or is being drained in the same cycle (`in_ready = !out_valid || out_ready`). While `out_valid` is high and `out_ready` is low, the output register keeps its contents unchanged. A new operation can be accepted every cycle as long as the consumer does not stall.

Operation codes on `op`: 0 add, 1 AND, 2 set-less-than, 3 NOT, 4 shift right, 5 address sum, 6 branch-if-zero, 7 branch-and-link.

Top module: `ex8_unit`

## Requirements
- R1: Code 0 (add) gives `opa + opb` modulo 256, with no branch.
- R2: Code 1 gives `opa & opb`. Code 3 gives `~opa`, and the value on `opb` has no effect on it.
- R3: Code 2 gives 8'h01 when `opa` is less than `opb` as signed two's-complement values, and 8'h00 otherwise.
- R4: Code 4 shifts `opa` right by exactly one bit and fills bit 7 with 0.
- R5: Code 5 (address sum for load, store and load-address) gives `opa + imm` modulo 256, with no branch.
- R6: Code 6 sets the taken flag exactly when `opa` is 8'h00. The target is `opb + imm` modulo 256 and the result is 8'h00.
- R7: Code 7 always sets the taken flag. The result is the link value `pc + 1` modulo 256 and the target is `opb + imm` modulo 256.
- R8: For codes 0 to 5 the taken flag is 0 and the target is 8'h00.
- R9: An accepted operation appears on the outputs, with `out_valid` high, on the edge that accepts it. `in_ready` equals `!out_valid || out_ready`. Outputs are held stable while `out_valid && !out_ready`. Results leave in the order they were accepted.
- R10: Synchronous reset clears `out_valid`, `res`, `br_taken` and `br_target` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present on the input side |
| in_ready | output | 1 | Unit can take an operation this cycle |
| op | input | 3 | Decoded operation code |
| opa | input | 8 | First register operand (also the tested register) |
| opb | input | 8 | Second register operand (also the branch base) |
| imm | input | 8 | Sign-extended immediate |
| pc | input | 8 | Address of the instruction |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| res | output | 8 | Result value |
| br_taken | output | 1 | Branch taken |
| br_target | output | 8 | Branch destination address |

## Verification
Every result, taken flag and target is due at the first rising edge after the operation is accepted, because it passes through exactly one register. It then stays on the outputs until the consumer takes it. The bench changes its inputs just after each falling edge and decides about each handshake shortly afterwards, once `in_ready` has settled. It keeps a queue of expected values: an entry is added on each accepted input and removed only on an output handshake. Stalled cycles are compared against the values held in the previous cycle.

// File: rtl/ex8_pkg.sv
package ex8_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_AND  = 3'd1,
    OP_SLT  = 3'd2,
    OP_NOT  = 3'd3,
    OP_SHR  = 3'd4,
    OP_ADDR = 3'd5,
    OP_BZ   = 3'd6,
    OP_BAL  = 3'd7
  } ex8_op_e;
  localparam int OP_W = 3;
endpackage

// File: rtl/ex8_alu.sv
module ex8_alu #(
  parameter int DW = 8
) (
  input  logic [ex8_pkg::OP_W-1:0] op,
  input  logic [DW-1:0]            a,
  input  logic [DW-1:0]            b,
  input  logic [DW-1:0]            imm,
  output logic [DW-1:0]            y
);
  import ex8_pkg::*;
  logic lt;
  assign lt = $signed(a) < $signed(b);

  always_comb begin
    unique case (ex8_op_e'(op))
      OP_ADD:  y = a + b;
      OP_AND:  y = a & b;
      OP_SLT:  y = {{(DW-1){1'b0}}, lt};
      OP_NOT:  y = ~a;
      OP_SHR:  y = {1'b0, a[DW-1:1]};
      OP_ADDR: y = a + imm;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/ex8_branch.sv
module ex8_branch #(
  parameter int DW = 8
) (
  input  logic [ex8_pkg::OP_W-1:0] op,
  input  logic [DW-1:0]            a,
  input  logic [DW-1:0]            b,
  input  logic [DW-1:0]            imm,
  input  logic [DW-1:0]            pc,
  output logic                     taken,
  output logic [DW-1:0]            target,
  output logic [DW-1:0]            link,
  output logic                     is_link
);
  import ex8_pkg::*;
  logic is_bz;
  assign is_bz   = (ex8_op_e'(op) == OP_BZ);
  assign is_link = (ex8_op_e'(op) == OP_BAL);
  assign taken   = is_link || (is_bz && (a == '0));
  assign target  = (is_bz || is_link) ? DW'(b + imm) : '0;
  assign link    = DW'(pc + DW'(1));
endmodule

// File: rtl/ex8_outreg.sv
module ex8_outreg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] d_res,
  input  logic          d_taken,
  input  logic [DW-1:0] d_target,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] q_res,
  output logic          q_taken,
  output logic [DW-1:0] q_target
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      q_res     <= '0;
      q_taken   <= 1'b0;
      q_target  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        q_res    <= d_res;
        q_taken  <= d_taken;
        q_target <= d_target;
      end
    end
  end
endmodule

// File: rtl/ex8_unit.sv
module ex8_unit #(
  parameter int DW = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [ex8_pkg::OP_W-1:0] op,
  input  logic [DW-1:0]            opa,
  input  logic [DW-1:0]            opb,
  input  logic [DW-1:0]            imm,
  input  logic [DW-1:0]            pc,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [DW-1:0]            res,
  output logic                     br_taken,
  output logic [DW-1:0]            br_target
);
  logic [DW-1:0] alu_y, link, tgt, nxt_res;
  logic          tk, is_link;

  ex8_alu #(.DW(DW)) u_alu (
    .op(op), .a(opa), .b(opb), .imm(imm), .y(alu_y)
  );

  ex8_branch #(.DW(DW)) u_br (
    .op(op), .a(opa), .b(opb), .imm(imm), .pc(pc),
    .taken(tk), .target(tgt), .link(link), .is_link(is_link)
  );

  assign nxt_res = is_link ? link : alu_y;

  ex8_outreg #(.DW(DW)) u_reg (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready),
    .d_res(nxt_res), .d_taken(tk), .d_target(tgt),
    .out_valid(out_valid), .out_ready(out_ready),
    .q_res(res), .q_taken(br_taken), .q_target(br_target)
  );
endmodule

// File: rtl/ex8_unit_chk.sv
module ex8_unit_chk #(
  parameter int DW = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic [ex8_pkg::OP_W-1:0] op,
  input logic [DW-1:0]            opa,
  input logic [DW-1:0]            opb,
  input logic [DW-1:0]            imm,
  input logic [DW-1:0]            pc,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic [DW-1:0]            res,
  input logic                     br_taken,
  input logic [DW-1:0]            br_target
);
  import ex8_pkg::*;
  logic acc;
  assign acc = in_valid && in_ready;

  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (!out_valid && res == '0 && !br_taken && br_target == '0));

  assert_accept_shows_R9: assert property (@(posedge clk) disable iff (rst)
    acc |=> out_valid);

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(res) && $stable(br_taken) && $stable(br_target)));

  assert_add_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (acc && op == OP_ADD) |=> (res == DW'($past(opa) + $past(opb))));

  assert_slt_bool_R3: assert property (@(posedge clk) disable iff (rst)
    (acc && op == OP_SLT) |=> (res[DW-1:1] == '0));

  assert_shr_msb_R4: assert property (@(posedge clk) disable iff (rst)
    (acc && op == OP_SHR) |=> !res[DW-1]);

  assert_bz_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
    (acc && op == OP_BZ && opa != '0) |=> !br_taken);

  assert_bal_link_R7: assert property (@(posedge clk) disable iff (rst)
    (acc && op == OP_BAL) |=> (br_taken && res == DW'($past(pc) + DW'(1))));

  assert_no_branch_R8: assert property (@(posedge clk) disable iff (rst)
    (acc && op <= OP_ADDR) |=> (!br_taken && br_target == '0));
endmodule

bind ex8_unit ex8_unit_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .op(op), .opa(opa), .opb(opb), .imm(imm), .pc(pc),
  .out_valid(out_valid), .out_ready(out_ready), .res(res),
  .br_taken(br_taken), .br_target(br_target)
);

// File: tb/sim_ex8_unit.sv
`timescale 1ns/1ps
module sim_ex8_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0, out_ready = 1'b0;
  logic [2:0] op = '0;
  logic [7:0] opa = '0, opb = '0, imm = '0, pc = '0;
  logic       in_ready, out_valid, br_taken;
  logic [7:0] res, br_target;

  typedef struct packed {
    logic [7:0] r;
    logic       t;
    logic [7:0] g;
  } exp_t;

  exp_t q[$];
  int   total = 0, bad = 0;
  logic held = 1'b0;
  exp_t snap;

  always #4 clk = ~clk;

  ex8_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .op(op), .opa(opa), .opb(opb), .imm(imm), .pc(pc),
    .out_valid(out_valid), .out_ready(out_ready), .res(res),
    .br_taken(br_taken), .br_target(br_target)
  );

  function automatic exp_t model(input logic [2:0] o, input logic [7:0] a, b, i, p);
    exp_t e;
    e = '0;
    case (o)
      3'd0: e.r = a + b;                                   // R1
      3'd1: e.r = a & b;                                   // R2
      3'd2: e.r = ($signed(a) < $signed(b)) ? 8'h01 : 8'h00; // R3
      3'd3: e.r = ~a;                                      // R2
      3'd4: e.r = a >> 1;                                  // R4
      3'd5: e.r = a + i;                                   // R5
      3'd6: begin e.t = (a == 8'h00); e.g = b + i; end     // R6
      default: begin e.r = p + 8'd1; e.t = 1'b1; e.g = b + i; end // R7
    endcase
    return e;
  endfunction

  function automatic string tag(input logic [2:0] o);
    case (o)
      3'd0: return "R1"; 3'd1: return "R2"; 3'd2: return "R3"; 3'd3: return "R2";
      3'd4: return "R4"; 3'd5: return "R5"; 3'd6: return "R6"; default: return "R7";
    endcase
  endfunction

  // one cycle: drive just after the falling edge, settle, then book handshakes
  task automatic cyc(input logic v, input logic [2:0] o, input logic [7:0] a, b, i, p,
                     input logic rdy);
    exp_t e, got;
    @(negedge clk);
    in_valid = v; op = o; opa = a; opb = b; imm = i; pc = p; out_ready = rdy;
    #1;
    got = '{r: res, t: br_taken, g: br_target};
    if (held) begin
      total++;
      if (!out_valid || got != snap) begin
        bad++;
        $display("FAIL R9 stall hold: got v=%0b %h expected v=1 %h", out_valid, got, snap);
      end
    end
    total++;
    if (in_ready !== (!out_valid || out_ready)) begin
      bad++;
      $display("FAIL R9 in_ready=%0b expected %0b", in_ready, !out_valid || out_ready);
    end
    if (out_valid && out_ready) begin
      total++;
      if (q.size() == 0) begin
        bad++;
        $display("FAIL R9 unexpected output %h expected none", got);
      end else begin
        e = q.pop_front();
        if (got != e) begin
          bad++;
          $display("FAIL R1-path/%s-class result: got res=%h tk=%0b tg=%h expected res=%h tk=%0b tg=%h (R8 for codes 0-5)",
                   "mixed", got.r, got.t, got.g, e.r, e.t, e.g);
        end
      end
    end
    held = out_valid && !out_ready;
    snap = got;
    if (v && in_ready) q.push_back(model(o, a, b, i, p));
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog expired: got running expected finished");
    $display("  test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #1;
    total++; // R10 reset state
    if (out_valid || res != 0 || br_taken || br_target != 0) begin
      bad++;
      $display("FAIL R10 reset: got v=%0b res=%h tk=%0b tg=%h expected all 0",
               out_valid, res, br_taken, br_target);
    end
    @(negedge clk); rst = 1'b0;

    // directed corners
    cyc(1, 3'd0, 8'hFF, 8'h01, 8'h00, 8'h00, 1); // R1 wrap to 0
    cyc(1, 3'd2, 8'h80, 8'h01, 8'h00, 8'h00, 1); // R3 -128 < 1
    cyc(1, 3'd2, 8'h7F, 8'h80, 8'h00, 8'h00, 1); // R3 127 !< -128
    cyc(1, 3'd2, 8'h05, 8'h05, 8'h00, 8'h00, 1); // R3 equal
    cyc(1, 3'd4, 8'hFF, 8'h00, 8'h00, 8'h00, 1); // R4 msb 0
    cyc(1, 3'd3, 8'h5A, 8'hFF, 8'h00, 8'h00, 1); // R2 NOT, opb ignored
    cyc(1, 3'd3, 8'h5A, 8'h00, 8'h00, 8'h00, 1); // R2 NOT, opb ignored
    cyc(1, 3'd1, 8'hF0, 8'h3C, 8'h00, 8'h00, 1); // R2 AND
    cyc(1, 3'd5, 8'h10, 8'h99, 8'hFE, 8'h00, 1); // R5 negative imm
    cyc(1, 3'd6, 8'h00, 8'h20, 8'h05, 8'h00, 1); // R6 taken
    cyc(1, 3'd6, 8'h01, 8'h20, 8'h05, 8'h00, 1); // R6 not taken
    cyc(1, 3'd7, 8'h33, 8'hF0, 8'h20, 8'hFF, 1); // R7 link wraps, target wraps
    cyc(1, 3'd7, 8'h33, 8'h40, 8'h02, 8'h10, 0); // R9 stall start
    cyc(1, 3'd0, 8'h01, 8'h02, 8'h00, 8'h00, 0); // R9 held, input refused
    cyc(0, 3'd0, 8'h00, 8'h00, 8'h00, 8'h00, 1);

    // constrained random, R1..R9
    for (int k = 0; k < 3000; k++) begin
      cyc($urandom_range(0, 3) != 0, 3'($urandom_range(0, 7)),
          8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
          $urandom_range(0, 3) != 0);
    end
    for (int k = 0; k < 4; k++) cyc(0, 3'd0, 8'h00, 8'h00, 8'h00, 8'h00, 1);

    total++; // R9 everything delivered in order
    if (q.size() != 0) begin
      bad++;
      $display("FAIL R9 pending results: got %0d expected 0", q.size());
    end

    // R10 reset mid-stream
    cyc(1, 3'd7, 8'h00, 8'h01, 8'h01, 8'h01, 0);
    @(negedge clk); rst = 1'b1; in_valid = 1'b0;
    @(negedge clk); #1;
    total++;
    if (out_valid || res != 0 || br_taken || br_target != 0) begin
      bad++;
      $display("FAIL R10 reset clear: got v=%0b res=%h tk=%0b tg=%h expected all 0",
               out_valid, res, br_taken, br_target);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule